// File: doc/BRIEF.md
# Nonvolatile Memory Erase/Program Timing Sequencer

This block sets the duration of each erase or program operation on an on-chip nonvolatile data array. A prescaler divides the system clock into a slow tick. A 10-bit timing counter counts those ticks through two phases in turn. The first phase is the high-voltage pulse, and its length is set by a byte-wide pulse-time register. The second phase is a recovery delay, and its length is set by a byte-wide end-time register. The block reports busy for the whole operation and raises a one-cycle done strobe when it returns to idle.

A byte-wide key register guards the array. Array writes and new operations are accepted only while the key holds its unlock value. Array reads and writes are refused while an operation runs. A start request that is refused sets a sticky error flag, and any write to the status address clears that flag. Software can read back the prescaler count and the timing counter through read-only addresses.

Top module: `flash_timing_seq`

## Requirements
- R1: After reset the registers hold these values: pulse-time 0x31, end-time 0x00, key 0xC9. Busy, done and the error flag are low. Both count views read zero.
- R2: While busy, the prescaler counts clock cycles 0..PRESCALE_DIV-1 and emits one tick per PRESCALE_DIV cycles. Its count reads back at address 4 and is held at zero while idle.
- R3: An accepted start loads the counter with the pulse-time value in bits [9:2] and binary 11 in bits [1:0]. The counter drops by one per tick, so the pulse lasts 4×(value+1) ticks.
- R4: When the pulse count is zero at a tick, the counter is loaded with the end-time value in bits [7:0] and 00 in bits [9:8]. The recovery delay then lasts value+1 ticks.
- R5: Busy stays high for exactly (4×(P+1)+E+1)×PRESCALE_DIV cycles after the start is accepted, where P is the pulse-time value and E the end-time value. Done is high for one cycle on the return to idle.
- R6: Writes to the pulse-time (address 0) and end-time (address 1) registers have no effect while busy.
- R7: An array write request is granted only while the key register (address 2) holds 0xC9 and the block is idle. Writing any other key value locks the array. Writing 0xC9 unlocks it, and the unlock holds for any number of array writes.
- R8: Array read requests are refused while busy and granted while idle.
- R9: A start request made while the key is not 0xC9, or while busy, does not start or disturb an operation and sets the sticky error flag. Any write to address 3 clears the flag. If a set and a clear fall in the same cycle, the set wins.
- R10: Address 3 reads the error flag in bit 0 and busy in bit 1. Address 5 reads the 10-bit timing counter with its upper six bits zero. Unmapped addresses read zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| reg_wr | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | VAL_W | Register write data |
| reg_rdata | output | RD_W | Read data for reg_addr (combinational) |
| op_start | input | 1 | Request to start an erase/program operation |
| arr_rd_req | input | 1 | Array read request |
| arr_wr_req | input | 1 | Array write request |
| arr_rd_gnt | output | 1 | Array read allowed |
| arr_wr_gnt | output | 1 | Array write allowed |
| busy | output | 1 | Operation in progress |
| done | output | 1 | One-cycle strobe at the end of an operation |
| op_err | output | 1 | Sticky refused-start flag |

## Verification
The assertions check several rules on every cycle. The counter moves only on a tick and drops by exactly one. The pulse phase hands over to the end phase with the end-time value loaded. Ticks are never back to back, and the prescaler sits at zero while idle. The configuration registers stay frozen while busy. Done never lasts two cycles or overlaps busy. A refused start always leaves the error flag set, and the flag holds until a clear. Only the bench scenarios can show the end-to-end duration of whole operations for many value pairs, including the 0/0, 255/255 and mass-erase settings. The same holds for the lock and unlock sequence of the key and for the exact read-back values at chosen points inside an operation.

// File: rtl/flt_pkg.sv
package flt_pkg;
   typedef enum logic [1:0] {
      ST_IDLE  = 2'd0,
      ST_PULSE = 2'd1,
      ST_END   = 2'd2
   } flt_state_e;

   localparam logic [2:0] A_PULSE  = 3'd0;
   localparam logic [2:0] A_END    = 3'd1;
   localparam logic [2:0] A_KEY    = 3'd2;
   localparam logic [2:0] A_STATUS = 3'd3;
   localparam logic [2:0] A_PCNT   = 3'd4;
   localparam logic [2:0] A_TCNT   = 3'd5;
endpackage

// File: rtl/flt_prescaler.sv
module flt_prescaler #(
   parameter int DIV = 40,
   parameter int PW  = 6
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          run,
   output logic          tick,
   output logic [PW-1:0] pcount
);
   generate
      if (DIV == 1) begin : g_bypass
         assign tick   = run;
         assign pcount = '0;
      end else begin : g_count
         localparam logic [PW-1:0] LAST = PW'(DIV - 1);
         logic [PW-1:0] cnt_q;

         always_ff @(posedge clk or negedge rst_n) begin
            if (!rst_n)           cnt_q <= '0;
            else if (!run)        cnt_q <= '0;
            else if (cnt_q == LAST) cnt_q <= '0;
            else                  cnt_q <= cnt_q + PW'(1);
         end

         assign tick   = run && (cnt_q == LAST);
         assign pcount = cnt_q;

         // R2: ticks are spaced by the divisor, never adjacent
         a_r2_tick_spacing: assert property (@(posedge clk) disable iff (!rst_n)
            tick |=> !tick);
         // R2: prescaler parked at zero while idle
         a_r2_idle_zero: assert property (@(posedge clk) disable iff (!rst_n)
            !run |=> (pcount == '0));
      end
   endgenerate
endmodule

// File: rtl/flt_timer.sv
module flt_timer
   import flt_pkg::*;
#(
   parameter int VW = 8,
   parameter int LW = 2,
   parameter int CW = VW + LW
) (
   input  logic          clk,
   input  logic          rst_n,
   input  logic          start_ok,
   input  logic          tick,
   input  logic [VW-1:0] pulse_val,
   input  logic [VW-1:0] end_val,
   output logic          busy,
   output logic          done,
   output logic [CW-1:0] count
);
   flt_state_e    state_q;
   logic [CW-1:0] cnt_q;
   logic          done_q;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         state_q <= ST_IDLE;
         cnt_q   <= '0;
         done_q  <= 1'b0;
      end else begin
         done_q <= 1'b0;
         case (state_q)
            ST_IDLE: begin
               if (start_ok) begin
                  state_q <= ST_PULSE;
                  cnt_q   <= {pulse_val, {LW{1'b1}}};
               end
            end
            ST_PULSE: begin
               if (tick) begin
                  if (cnt_q == '0) begin
                     state_q <= ST_END;
                     cnt_q   <= {{LW{1'b0}}, end_val};
                  end else begin
                     cnt_q <= cnt_q - CW'(1);
                  end
               end
            end
            ST_END: begin
               if (tick) begin
                  if (cnt_q == '0) begin
                     state_q <= ST_IDLE;
                     done_q  <= 1'b1;
                  end else begin
                     cnt_q <= cnt_q - CW'(1);
                  end
               end
            end
            default: state_q <= ST_IDLE;
         endcase
      end
   end

   assign busy  = (state_q != ST_IDLE);
   assign done  = done_q;
   assign count = cnt_q;

   // R3: counter moves only on a prescaler tick while busy
   a_r3_hold_without_tick: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && !tick) |=> $stable(cnt_q));
   // R3: each tick takes exactly one off a nonzero count
   a_r3_step_by_one: assert property (@(posedge clk) disable iff (!rst_n)
      (busy && tick && cnt_q != '0) |=> (cnt_q == $past(cnt_q) - CW'(1)));
   // R4: pulse expiry loads the end-time value into the low bits
   a_r4_end_load: assert property (@(posedge clk) disable iff (!rst_n)
      (state_q == ST_PULSE && tick && cnt_q == '0) |=>
         (state_q == ST_END && cnt_q == {{LW{1'b0}}, $past(end_val)}));
   // R5: done is a single-cycle strobe outside busy
   a_r5_done_single: assert property (@(posedge clk) disable iff (!rst_n)
      done |=> !done);
   a_r5_done_idle: assert property (@(posedge clk) disable iff (!rst_n)
      done |-> !busy);
endmodule

// File: rtl/flt_regs.sv
module flt_regs
   import flt_pkg::*;
#(
   parameter int              VW       = 8,
   parameter int              PW       = 6,
   parameter int              CW       = 10,
   parameter int              RD_W     = 16,
   parameter logic [VW-1:0]   KEY_VAL  = 8'hC9,
   parameter logic [VW-1:0]   PULSE_RST = 8'h31,
   parameter logic [VW-1:0]   END_RST  = 8'h00
) (
   input  logic            clk,
   input  logic            rst_n,
   input  logic            wr,
   input  logic [2:0]      addr,
   input  logic [VW-1:0]   wdata,
   input  logic            busy,
   input  logic            start,
   input  logic [PW-1:0]   pcount,
   input  logic [CW-1:0]   tcount,
   output logic [RD_W-1:0] rdata,
   output logic [VW-1:0]   pulse_val,
   output logic [VW-1:0]   end_val,
   output logic            key_ok,
   output logic            start_ok,
   output logic            err
);
   logic [VW-1:0] pulse_q, end_q, key_q;
   logic          err_q;
   logic          cfg_wr;

   assign cfg_wr   = wr && !busy;
   assign key_ok   = (key_q == KEY_VAL);
   assign start_ok = start && key_ok && !busy;

   always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) begin
         pulse_q <= PULSE_RST;
         end_q   <= END_RST;
         key_q   <= KEY_VAL;
         err_q   <= 1'b0;
      end else begin
         if (cfg_wr && addr == A_PULSE) pulse_q <= wdata;
         if (cfg_wr && addr == A_END)   end_q   <= wdata;
         if (wr && addr == A_KEY)       key_q   <= wdata;
         if (start && !start_ok)            err_q <= 1'b1;
         else if (wr && addr == A_STATUS)   err_q <= 1'b0;
      end
   end

   always_comb begin
      case (addr)
         A_PULSE:  rdata = RD_W'(pulse_q);
         A_END:    rdata = RD_W'(end_q);
         A_KEY:    rdata = RD_W'(key_q);
         A_STATUS: rdata = RD_W'({busy, err_q});
         A_PCNT:   rdata = RD_W'(pcount);
         A_TCNT:   rdata = RD_W'(tcount);
         default:  rdata = '0;
      endcase
   end

   assign pulse_val = pulse_q;
   assign end_val   = end_q;
   assign err       = err_q;

   // R6: timing configuration is frozen for the whole operation
   a_r6_cfg_frozen: assert property (@(posedge clk) disable iff (!rst_n)
      busy |=> ($stable(pulse_q) && $stable(end_q)));
   // R9: a refused start always leaves the flag set
   a_r9_err_on_refusal: assert property (@(posedge clk) disable iff (!rst_n)
      (start && (busy || !key_ok)) |=> err_q);
   // R9: flag persists until a status write
   a_r9_err_sticky: assert property (@(posedge clk) disable iff (!rst_n)
      (err_q && !(wr && addr == A_STATUS)) |=> err_q);
endmodule

// File: rtl/flash_timing_seq.sv
module flash_timing_seq #(
   parameter int                PRESCALE_DIV = 40,
   parameter int                VAL_W        = 8,
   parameter int                LOW_W        = 2,
   parameter int                RD_W         = 16,
   parameter logic [VAL_W-1:0]  KEY_VAL      = 8'hC9,
   parameter logic [VAL_W-1:0]  PULSE_RST    = 8'h31,
   parameter logic [VAL_W-1:0]  END_RST      = 8'h00
) (
   input  logic             clk,
   input  logic             rst_n,
   input  logic             reg_wr,
   input  logic [2:0]       reg_addr,
   input  logic [VAL_W-1:0] reg_wdata,
   output logic [RD_W-1:0]  reg_rdata,
   input  logic             op_start,
   input  logic             arr_rd_req,
   input  logic             arr_wr_req,
   output logic             arr_rd_gnt,
   output logic             arr_wr_gnt,
   output logic             busy,
   output logic             done,
   output logic             op_err
);
   localparam int CNT_W = VAL_W + LOW_W;
   localparam int PS_W  = (PRESCALE_DIV > 1) ? $clog2(PRESCALE_DIV) : 1;

   generate
      if (PRESCALE_DIV < 1) begin : g_bad_div
         $error("PRESCALE_DIV must be at least 1");
      end
      if (VAL_W < 1 || LOW_W < 1) begin : g_bad_width
         $error("VAL_W and LOW_W must be positive");
      end
      if (RD_W < CNT_W || RD_W < VAL_W || RD_W < PS_W) begin : g_bad_rd
         $error("RD_W too narrow for the read-back views");
      end
   endgenerate

   logic             tick, start_ok, key_ok;
   logic [PS_W-1:0]  pcount;
   logic [CNT_W-1:0] tcount;
   logic [VAL_W-1:0] pulse_val, end_val;

   flt_prescaler #(.DIV(PRESCALE_DIV), .PW(PS_W)) u_pre (
      .clk(clk), .rst_n(rst_n), .run(busy), .tick(tick), .pcount(pcount)
   );

   flt_timer #(.VW(VAL_W), .LW(LOW_W), .CW(CNT_W)) u_tmr (
      .clk(clk), .rst_n(rst_n), .start_ok(start_ok), .tick(tick),
      .pulse_val(pulse_val), .end_val(end_val),
      .busy(busy), .done(done), .count(tcount)
   );

   flt_regs #(
      .VW(VAL_W), .PW(PS_W), .CW(CNT_W), .RD_W(RD_W),
      .KEY_VAL(KEY_VAL), .PULSE_RST(PULSE_RST), .END_RST(END_RST)
   ) u_regs (
      .clk(clk), .rst_n(rst_n), .wr(reg_wr), .addr(reg_addr), .wdata(reg_wdata),
      .busy(busy), .start(op_start), .pcount(pcount), .tcount(tcount),
      .rdata(reg_rdata), .pulse_val(pulse_val), .end_val(end_val),
      .key_ok(key_ok), .start_ok(start_ok), .err(op_err)
   );

   assign arr_wr_gnt = arr_wr_req && key_ok && !busy;
   assign arr_rd_gnt = arr_rd_req && !busy;
endmodule

// File: tb/flash_timing_seq_test.sv
module flash_timing_seq_test;
   localparam int DIV = 3;

   logic        clk = 1'b0;
   logic        rst_n = 1'b0;
   logic        reg_wr = 1'b0;
   logic [2:0]  reg_addr = 3'd0;
   logic [7:0]  reg_wdata = 8'd0;
   logic [15:0] reg_rdata;
   logic        op_start = 1'b0;
   logic        arr_rd_req = 1'b0, arr_wr_req = 1'b0;
   logic        arr_rd_gnt, arr_wr_gnt, busy, done, op_err;

   int n_chk = 0;
   int n_fail = 0;

   always #4 clk = ~clk;

   flash_timing_seq #(.PRESCALE_DIV(DIV)) uut (
      .clk(clk), .rst_n(rst_n), .reg_wr(reg_wr), .reg_addr(reg_addr),
      .reg_wdata(reg_wdata), .reg_rdata(reg_rdata), .op_start(op_start),
      .arr_rd_req(arr_rd_req), .arr_wr_req(arr_wr_req),
      .arr_rd_gnt(arr_rd_gnt), .arr_wr_gnt(arr_wr_gnt),
      .busy(busy), .done(done), .op_err(op_err)
   );

   task automatic check(input bit ok, input string req, input int act, input int exp);
      n_chk++;
      if (!ok) begin
         n_fail++;
         $display("FAIL %s actual=%0h expected=%0h", req, act, exp);
      end
   endtask

   function automatic int op_cycles(input int p, input int e);
      return (4 * (p + 1) + e + 1) * DIV;
   endfunction

   task automatic wr_reg(input logic [2:0] a, input logic [7:0] d);
      reg_addr = a; reg_wdata = d; reg_wr = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0;
   endtask

   task automatic rd_chk(input logic [2:0] a, input int exp, input string req);
      reg_addr = a;
      #1;
      check(reg_rdata == 16'(exp), req, reg_rdata, exp);
   endtask

   // one full operation with pulse value p and end value e
   task automatic run_op(input int p, input int e, input bit noise);
      int k;
      wr_reg(3'd0, 8'(p));
      wr_reg(3'd1, 8'(e));
      reg_addr = 3'd5;
      op_start = 1'b1;
      @(negedge clk);
      op_start = 1'b0;
      k = 1;
      check(busy == 1'b1, "R5 busy after start", busy, 1);
      check(reg_rdata == 16'((p << 2) | 3), "R3 pulse load", reg_rdata, (p << 2) | 3);
      while (busy && k < 5000) begin
         if (k == 2 && DIV > 1) begin
            reg_addr = 3'd4; #1;
            check(reg_rdata == 16'd1, "R2 prescaler count", reg_rdata, 1);
            reg_addr = 3'd5;
         end
         if (noise && k == 2) begin
            reg_addr = 3'd0; reg_wdata = ~8'(p); reg_wr = 1'b1;
         end
         if (noise && k == 3) begin
            reg_addr = 3'd1; reg_wdata = ~8'(e); reg_wr = 1'b1; op_start = 1'b1;
         end
         if (noise && k == 4) begin
            reg_addr = 3'd5; reg_wr = 1'b0; op_start = 1'b0;
         end
         if (k == DIV + 1) begin
            #1;
            check(reg_rdata == 16'((p << 2) | 2), "R3 one tick down", reg_rdata, (p << 2) | 2);
         end
         if (k == 4 * (p + 1) * DIV + 1) begin
            #1;
            check(reg_rdata == 16'(e), "R4 end load", reg_rdata, e);
         end
         if (noise && k > 4) begin
            arr_rd_req = 1'($urandom); arr_wr_req = 1'($urandom);
            #1;
            if (arr_rd_gnt || arr_wr_gnt) check(1'b0, "R8 R7 grant while busy", {arr_rd_gnt, arr_wr_gnt}, 0);
         end
         @(negedge clk);
         k++;
      end
      arr_rd_req = 1'b0; arr_wr_req = 1'b0;
      check(k - 1 == op_cycles(p, e), "R5 busy length", k - 1, op_cycles(p, e));
      check(done == 1'b1, "R5 done strobe", done, 1);
      @(negedge clk);
      check(done == 1'b0, "R5 done single", done, 0);
      if (noise) begin
         rd_chk(3'd0, p, "R6 pulse frozen");
         rd_chk(3'd1, e, "R6 end frozen");
         check(op_err == 1'b1, "R9 busy start flagged", op_err, 1);
         wr_reg(3'd3, 8'h00);
         check(op_err == 1'b0, "R9 flag cleared", op_err, 0);
      end
   endtask

   initial begin
      #(8 * 190000);
      n_fail++;
      $display("FAIL watchdog actual=hung expected=finish");
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end

   initial begin
      int unused;
      unused = $urandom(32'h5EED);
      repeat (3) @(negedge clk);
      rst_n = 1'b1;
      @(negedge clk);

      // R1 reset state
      rd_chk(3'd0, 8'h31, "R1 pulse reset");
      rd_chk(3'd1, 8'h00, "R1 end reset");
      rd_chk(3'd2, 8'hC9, "R1 key reset");
      rd_chk(3'd3, 0, "R1 R10 status reset");
      rd_chk(3'd4, 0, "R1 prescaler view");
      rd_chk(3'd5, 0, "R1 timer view");
      rd_chk(3'd7, 0, "R10 unmapped");
      check(busy == 0 && done == 0 && op_err == 0, "R1 outputs", {busy, done, op_err}, 0);

      // R7 R8 idle grants with unlocked key
      arr_wr_req = 1'b1; arr_rd_req = 1'b1; #1;
      check(arr_wr_gnt == 1'b1, "R7 write granted unlocked", arr_wr_gnt, 1);
      check(arr_rd_gnt == 1'b1, "R8 read granted idle", arr_rd_gnt, 1);
      @(negedge clk);
      wr_reg(3'd2, 8'h00);
      check(arr_wr_gnt == 1'b0, "R7 locked", arr_wr_gnt, 0);
      check(arr_rd_gnt == 1'b1, "R8 read unaffected by key", arr_rd_gnt, 1);
      arr_wr_req = 1'b0; arr_rd_req = 1'b0;

      // R9 refused start with locked key
      op_start = 1'b1;
      @(negedge clk);
      op_start = 1'b0;
      check(busy == 1'b0, "R9 no start when locked", busy, 0);
      check(op_err == 1'b1, "R9 locked start flagged", op_err, 1);
      rd_chk(3'd3, 1, "R10 status err bit");
      @(negedge clk);
      check(op_err == 1'b1, "R9 sticky", op_err, 1);

      // R9 set wins over simultaneous clear
      reg_addr = 3'd3; reg_wr = 1'b1; op_start = 1'b1;
      @(negedge clk);
      reg_wr = 1'b0; op_start = 1'b0;
      check(op_err == 1'b1, "R9 set beats clear", op_err, 1);
      wr_reg(3'd3, 8'hFF);
      check(op_err == 1'b0, "R9 clear", op_err, 0);

      // R7 unlock persists across writes
      wr_reg(3'd2, 8'hC9);
      arr_wr_req = 1'b1;
      repeat (3) begin
         #1;
         check(arr_wr_gnt == 1'b1, "R7 unlock persists", arr_wr_gnt, 1);
         @(negedge clk);
      end
      arr_wr_req = 1'b0;

      // directed corner cases
      run_op(0, 0, 1'b0);
      run_op(8'hC7, 8'h13, 1'b1);
      run_op(255, 255, 1'b1);
      run_op(8'h31, 0, 1'b0);
      reg_addr = 3'd3; #1;
      check(reg_rdata[1] == 1'b0, "R10 status busy idle", reg_rdata[1], 0);

      // random operations
      for (int i = 0; i < 8; i++) begin
         run_op(int'($urandom_range(0, 255)), int'($urandom_range(0, 255)), 1'($urandom));
      end

      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
   end
endmodule